// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block keeps an asynchronous DRAM's contents alive. A free-running interval timer raises a refresh request every fixed number of clocks. When the access controller grants the shared DRAM bus, the block runs one refresh cycle on the active-low strobes and then hands the bus back. All timing limits are counted in clock cycles and set by parameters.

Two refresh styles are available, and the style is chosen for each cycle when the cycle starts. In the row-address style, the row to refresh comes from an internal counter. It is placed on the address pins ahead of the row strobe and held until the strobe rises, while the column strobe stays high. In the column-first style, the column strobe falls before the row strobe and stays low while the row strobe is low, and the address pins stay at zero. In both styles the row strobe is held low for a minimum time and both strobes then recover before the request is dropped.

A request that cannot be served at once is held. If a second interval ends while a request is still waiting, a sticky overflow flag is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: `ref_req` goes high at the clock edge that completes every REFI clocks counted from reset, measured by a free-running timer.
- R2: A pending request keeps `ref_req` high for as long as `ref_gnt` stays low. It clears only at the end of a completed refresh cycle.
- R3: `overflow` sets when an interval ends while an earlier request is still pending, unless that request completes on the same edge. Once set, it stays high until reset.
- R4: A cycle starts only on an edge where a request is pending and `ref_gnt` is high. Whenever `ref_gnt` is low, `ras_n` and `cas_n` are 1, `addr` is 0 and `bus_drive` is 0.
- R5: When `cbr_mode` is 0 at the start of a cycle (row-address style), `addr` shows the row counter for T_ASR cycles before `ras_n` falls and for the whole time `ras_n` is low. `cas_n` stays 1 for the whole cycle.
- R6: When `cbr_mode` is 1 at the start of a cycle (column-first style), `cas_n` falls T_CSR cycles before `ras_n` falls and stays 0 until `ras_n` rises. `addr` stays 0.
- R7: In every cycle, `ras_n` stays low for exactly T_RAS cycles.
- R8: After `ras_n` rises, both strobes stay 1 for max(T_RP, T_CP) cycles while `ref_req` remains high. Only after that does the cycle end.
- R9: The row counter advances by one at the end of each row-address cycle and wraps from NUM_ROWS-1 to 0. Column-first cycles leave it unchanged.
- R10: While reset is low, `ref_req` is 0, `ras_n` and `cas_n` are 1, `addr` is 0 and `overflow` is 0. The row counter restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbr_mode | input | 1 | Style for the next cycle: 0 row-address, 1 column-first |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request: pending or cycle in progress |
| bus_drive | output | 1 | The block is driving the strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | ROW_W | Refresh row address (row-address style only) |
| overflow | output | 1 | Sticky missed-interval flag |

## Verification
The bench first runs a long series of row-address cycles with prompt grants. This shows the counter wrap and the address hold window, and separates them from the column-first ordering, which comes next in a run of its own. A stretch with the grant withheld then shows that a held request is not dropped and that overflow sets on the second interval rather than the first. Finally, a stretch that switches style every interval shows that the style is taken at cycle start and that column-first cycles do not move the row counter. A reference model in the bench is compared with every output on every clock.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_LEAD    = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RECOVER = 2'd3
   } ref_phase_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
   parameter int REFI = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   output logic pending_o,
   output logic overflow_o
);
   localparam int TW = (REFI > 1) ? $clog2(REFI) : 1;

   logic [TW-1:0] tmr_q;
   logic          tick;

   generate
      if (REFI < 2) begin : g_bad_refi
         $error("REFI must be at least 2");
      end
   endgenerate

   assign tick = (tmr_q == TW'(REFI - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q      <= '0;
         pending_o  <= 1'b0;
         overflow_o <= 1'b0;
      end else begin
         tmr_q <= tick ? '0 : tmr_q + 1'b1;
         if (tick)
            pending_o <= 1'b1;
         else if (done_i)
            pending_o <= 1'b0;
         if (tick && pending_o && !done_i)
            overflow_o <= 1'b1;
      end
   end

   // R3: overflow never clears once set
   a_r3_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overflow_o) |-> overflow_o);

   // R2: a pending request survives until a cycle completes
   a_r2_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !done_i) |=> pending_o);

endmodule

// File: rtl/dref_row_counter.sv
module dref_row_counter #(
   parameter int NUM_ROWS = 8,
   parameter int ROW_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [ROW_W-1:0] row_o
);
   localparam bit POW2 = ((NUM_ROWS & (NUM_ROWS - 1)) == 0) && ((1 << ROW_W) == NUM_ROWS);

   generate
      if (NUM_ROWS < 2) begin : g_bad_rows
         $error("NUM_ROWS must be at least 2");
      end
      if (POW2) begin : g_natural_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)     row_o <= '0;
            else if (adv_i) row_o <= row_o + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)     row_o <= '0;
            else if (adv_i) row_o <= (row_o == ROW_W'(NUM_ROWS - 1)) ? '0 : row_o + 1'b1;
         end
      end
   endgenerate

   // R9: the row only ever steps forward by one or wraps to zero
   a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_o) |-> (row_o == '0 || row_o == $past(row_o) + 1'b1));

endmodule

// File: rtl/dref_strobe_fsm.sv
module dref_strobe_fsm
   import dram_ref_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int T_ASR = 2,
   parameter int T_CSR = 2,
   parameter int T_RAS = 4,
   parameter int T_RP  = 3,
   parameter int T_CP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pending_i,
   input  logic             gnt_i,
   input  logic             cbr_mode_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             row_adv_o,
   output logic             drive_o,
   output logic             ras_n_o,
   output logic             cas_n_o,
   output logic [ROW_W-1:0] addr_o
);
   localparam int PRE_LEN = imax(T_RP, T_CP);
   localparam int MAX_LEN = imax(imax(T_ASR, T_CSR), imax(T_RAS, PRE_LEN));
   localparam int CW      = $clog2(MAX_LEN + 1);

   generate
      if (T_ASR < 1 || T_CSR < 1 || T_RAS < 1 || T_RP < 1 || T_CP < 1) begin : g_bad_timing
         $error("all strobe timings must be at least one cycle");
      end
   endgenerate

   ref_phase_e    ph_q;
   logic [CW-1:0] left_q;
   logic          cbr_q;
   logic          own;
   logic          last;

   assign last = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         left_q <= '0;
         cbr_q  <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (pending_i && gnt_i) begin
               ph_q   <= PH_LEAD;
               cbr_q  <= cbr_mode_i;
               left_q <= cbr_mode_i ? CW'(T_CSR - 1) : CW'(T_ASR - 1);
            end
            PH_LEAD: if (last) begin
               ph_q   <= PH_STROBE;
               left_q <= CW'(T_RAS - 1);
            end else left_q <= left_q - 1'b1;
            PH_STROBE: if (last) begin
               ph_q   <= PH_RECOVER;
               left_q <= CW'(PRE_LEN - 1);
            end else left_q <= left_q - 1'b1;
            PH_RECOVER: if (last) ph_q <= PH_IDLE;
                        else left_q <= left_q - 1'b1;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o    = (ph_q != PH_IDLE);
   assign done_o    = (ph_q == PH_RECOVER) && last;
   assign row_adv_o = done_o && !cbr_q;
   assign own       = busy_o && gnt_i;
   assign drive_o   = own;
   assign ras_n_o   = !(own && ph_q == PH_STROBE);
   assign cas_n_o   = !(own && cbr_q && (ph_q == PH_LEAD || ph_q == PH_STROBE));
   assign addr_o    = (own && !cbr_q) ? row_i : '0;

   // run length of the current low period of ras_n, for the R7 bound
   logic [CW-1:0] low_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        low_run_q <= '0;
      else if (!ras_n_o) low_run_q <= low_run_q + 1'b1;
      else               low_run_q <= '0;
   end

   // R7: ras_n never stays low longer than T_RAS
   a_r7_ras_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_o |-> (int'(low_run_q) < T_RAS));

   // R6: in column-first cycles cas_n is already low the cycle before ras_n falls
   a_r6_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n_o) && cbr_q) |-> ($past(!cas_n_o) && !cas_n_o));

   // R5: in row-address cycles the address is set up before ras_n falls and cas_n is idle
   a_r5_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n_o) && !cbr_q) |-> ($stable(addr_o) && cas_n_o));

   // R8: when ras_n rises the cycle is still in progress for recovery
   a_r8_recover: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> (busy_o && cas_n_o));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int NUM_ROWS = 8,
   parameter int REFI     = 40,
   parameter int T_ASR    = 2,
   parameter int T_CSR    = 2,
   parameter int T_RAS    = 4,
   parameter int T_RP     = 3,
   parameter int T_CP     = 2,
   localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cbr_mode,
   input  logic             ref_gnt,
   output logic             ref_req,
   output logic             bus_drive,
   output logic             ras_n,
   output logic             cas_n,
   output logic [ROW_W-1:0] addr,
   output logic             overflow
);
   logic             pending;
   logic             busy;
   logic             done;
   logic             row_adv;
   logic [ROW_W-1:0] row;

   dref_interval_timer #(.REFI(REFI)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done),
      .pending_o (pending),
      .overflow_o(overflow)
   );

   dref_row_counter #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_rows (
      .clk  (clk),
      .rst_n(rst_n),
      .adv_i(row_adv),
      .row_o(row)
   );

   dref_strobe_fsm #(
      .ROW_W(ROW_W), .T_ASR(T_ASR), .T_CSR(T_CSR),
      .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (pending),
      .gnt_i     (ref_gnt),
      .cbr_mode_i(cbr_mode),
      .row_i     (row),
      .busy_o    (busy),
      .done_o    (done),
      .row_adv_o (row_adv),
      .drive_o   (bus_drive),
      .ras_n_o   (ras_n),
      .cas_n_o   (cas_n),
      .addr_o    (addr)
   );

   assign ref_req = pending || busy;

   // R4: with no grant the strobes and address are quiet
   a_r4_no_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_gnt |-> (ras_n && cas_n && addr == '0 && !bus_drive));

   // R2: a refused request is not withdrawn
   a_r2_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_gnt) |=> ref_req);

endmodule

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
   localparam int NR = 8, REFI = 40, TASR = 2, TCSR = 2, TRAS = 4, TRP = 3, TCP = 2;
   localparam int PRE = (TRP > TCP) ? TRP : TCP;

   logic clk = 1'b0, rst_n = 1'b0, cbr_mode = 1'b0, ref_gnt = 1'b0;
   logic ref_req, bus_drive, ras_n, cas_n, overflow;
   logic [2:0] addr;
   always #4 clk = ~clk;

   dram_refresh_seq #(.NUM_ROWS(NR), .REFI(REFI), .T_ASR(TASR), .T_CSR(TCSR),
                      .T_RAS(TRAS), .T_RP(TRP), .T_CP(TCP)) u_dram_refresh_seq (
      .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .ref_gnt(ref_gnt),
      .ref_req(ref_req), .bus_drive(bus_drive), .ras_n(ras_n), .cas_n(cas_n),
      .addr(addr), .overflow(overflow));

   int n_chk = 0, n_bad = 0;
   bit hold = 1'b1, finished = 1'b0;

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_tmr, m_pend, m_ovf, m_row, m_ph, m_left, m_cbr;
   int s_done, s_tick, s_oldp;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_tmr = 0; m_pend = 0; m_ovf = 0; m_row = 0; m_ph = 0; m_left = 0; m_cbr = 0;
      end else begin
         s_done = (m_ph == 3 && m_left == 1);
         s_tick = (m_tmr == REFI - 1);
         s_oldp = m_pend;
         if (s_done && !m_cbr) m_row = (m_row + 1) % NR;
         if (m_ph == 0) begin
            if (s_oldp && ref_gnt) begin
               m_ph = 1; m_cbr = cbr_mode; m_left = cbr_mode ? TCSR : TASR;
            end
         end else if (m_left == 1) begin
            m_ph = (m_ph == 3) ? 0 : m_ph + 1;
            m_left = (m_ph == 2) ? TRAS : PRE;
         end else m_left--;
         if (s_tick && s_oldp && !s_done) m_ovf = 1;
         if (s_tick) m_pend = 1; else if (s_done) m_pend = 0;
         m_tmr = s_tick ? 0 : m_tmr + 1;
      end
   end

   // grant follows request one step later unless held off
   initial forever begin
      @(posedge clk); #2;
      ref_gnt = hold ? 1'b0 : ref_req;
   end

   // per-cycle comparison plus waveform measurements
   logic p_ras = 1'b1, p_cas = 1'b1;
   int cas_fall_t = 0, ras_fall_t = 0, cyc = 0, ro_seen = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         automatic int busy = (m_ph != 0);
         automatic int own  = busy && ref_gnt;
         automatic string t_req = ref_gnt ? "R1" : "R2";
         automatic string t_str = !ref_gnt ? "R4" : (m_ph == 3 ? "R8" : "R7");
         automatic string t_cas = !ref_gnt ? "R4" : (m_ph == 3 ? "R8" : "R6");
         automatic string t_adr = !ref_gnt ? "R4" : "R5";
         automatic int e_req  = (m_pend || busy);
         automatic int e_ras  = !(own && m_ph == 2);
         automatic int e_cas  = !(own && m_cbr && (m_ph == 1 || m_ph == 2));
         automatic int e_addr = (own && !m_cbr) ? m_row : 0;
         check(ref_req == e_req, t_req, ref_req, e_req);
         check(ras_n == e_ras, t_str, ras_n, e_ras);
         check(cas_n == e_cas, t_cas, cas_n, e_cas);
         check(addr == e_addr, t_adr, addr, e_addr);
         check(overflow == m_ovf, "R3", overflow, m_ovf);
         check(bus_drive == own, "R4", bus_drive, own);
         if (p_cas && !cas_n) cas_fall_t = cyc;
         if (p_ras && !ras_n) begin
            ras_fall_t = cyc;
            if (!cas_n) check(cyc - cas_fall_t == TCSR, "R6", cyc - cas_fall_t, TCSR);
            else begin
               check(addr == ro_seen % NR, "R9", addr, ro_seen % NR);
               ro_seen++;
            end
         end
         if (!p_ras && ras_n) check(cyc - ras_fall_t == TRAS, "R7", cyc - ras_fall_t, TRAS);
      end
      p_ras = ras_n; p_cas = cas_n;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_idle();
      step(1);
      while (ref_req) step(1);
   endtask

   initial begin
      step(3);
      @(negedge clk);
      check(ref_req == 0, "R10", ref_req, 0);
      check(ras_n == 1 && cas_n == 1, "R10", {ras_n, cas_n}, 3);
      check(addr == 0, "R10", addr, 0);
      check(overflow == 0, "R10", overflow, 0);
      step(1);
      rst_n = 1'b1; hold = 1'b0;
      step(10 * REFI);                 // row-address run, counter wraps
      cbr_mode = 1'b1; step(3 * REFI); // column-first run
      cbr_mode = 1'b0; step(2 * REFI);
      wait_idle(); hold = 1'b1;        // grant withheld: held request then overflow
      step(REFI + 2);
      @(negedge clk);
      check(ref_req == 1, "R2", ref_req, 1);
      step(REFI);
      @(negedge clk);
      check(overflow == 1, "R3", overflow, 1);
      step(1);
      hold = 1'b0;
      for (int k = 0; k < 6; k++) begin
         cbr_mode = k[0];
         step(REFI);
      end
      step(REFI);
      check(ro_seen >= 12, "R9", ro_seen, 12);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule